// File: doc/BRIEF.md
# Hash Engine Control Register Bank

This block is the software-facing control bank of a hash accelerator. A simple 32-bit bus reads and writes six registers: a mode word, the source address, the digest address, a key-buffer address, the data length, and the hash command. It also exposes a status word. The address-type registers keep only the bits that the selected device variant can address. The digest address is also forced to 8-byte alignment, and the length keeps 28 bits in every variant.

When software writes the command register, the block raises a one-cycle start pulse toward the hashing datapath. Alongside the pulse it presents the decoded algorithm, output-ordering and list-mode fields, and it sets a busy flag. When the datapath reports completion, busy drops and a sticky completion flag is set. That flag drives the interrupt line until software writes a one to its bit in the status word. The datapath and its memory traffic live outside this block.

Top module: `hash_ctl_regs`

## Requirements
- R1: After reset every register (mode 0x10, status 0x1c, source 0x20, digest 0x24, key 0x28, length 0x2c, command 0x30) reads zero, and `hash_irq` and `hash_start` are low.
- R2: The source and key registers keep the bits of a variant mask: 0x7fffffff for VARIANT 0, 0x3fffffff for VARIANT 1, and 0x0fffffff for VARIANT 2. An all-ones write reads back as that mask.
- R3: The digest register uses the same variant mask, and its bits 2:0 always read zero (all-ones reads 0x7ffffff8 for VARIANT 0).
- R4: The length register keeps bits 27:0 only (all-ones reads 0x0fffffff) in every variant.
- R5: A write to offset 0x30 raises `hash_start` for exactly the one cycle after the write edge, and the command reads back unchanged.
- R6: Status bit 0 (hash busy) sets with the start pulse and clears on the cycle after `hash_done`.
- R7: `hash_done` sets status bit 9 (completion) one edge later, and `hash_irq` equals that bit.
- R8: A status write with bit 9 set clears the completion flag, so status reads zero. A status write with bit 9 clear leaves the flag set.
- R9: If `hash_done` and a clearing status write arrive in the same cycle, the flag ends set.
- R10: The crypto and RSA fields of status (busy bits 1 and 2, completion bits 12 and 13) always read zero.
- R11: The algorithm code is taken from command bits {10,6,5,4} and reported on `hash_algo`: MD5 0000→0, SHA-1 0010→1, SHA-224 0100→2, SHA-256 0101→3, SHA-384 1110→4, SHA-512 0110→5, and any other value→7. Command bit 3 drives `hash_sha_be`, bit 2 drives `hash_md5_le`, and bit 18 drives `hash_sg_mode`.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Byte offset of the access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| hash_done | input | 1 | Completion pulse from the datapath |
| hash_start | output | 1 | One-cycle start request |
| hash_algo | output | 3 | Decoded algorithm |
| hash_sg_mode | output | 1 | Scatter-gather list mode |
| hash_sha_be | output | 1 | Big-endian SHA digest output |
| hash_md5_le | output | 1 | Little-endian MD5 digest output |
| hash_src | output | 32 | Masked source address |
| hash_dst | output | 32 | Masked, aligned digest address |
| hash_len | output | 32 | Masked data length |
| hash_irq | output | 1 | Hash completion interrupt |

## Verification
The assertions assume that `hash_done` arrives only after a start and never in the same cycle as a command write. The bench issues each completion pulse only after the start pulse has ended. The clear-priority property assumes that software does not clear in the same cycle as a completion. That collision is driven only in the single scenario dedicated to it, and the relevant property is guarded by `!hash_done`. All bus writes are single-cycle strobes driven on the falling edge, so no two command writes fall on adjacent edges.

// File: rtl/hash_regs_pkg.sv
package hash_regs_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFS_MODE = 8'h10;
  localparam logic [7:0] OFS_STS  = 8'h1c;
  localparam logic [7:0] OFS_SRC  = 8'h20;
  localparam logic [7:0] OFS_DST  = 8'h24;
  localparam logic [7:0] OFS_KEY  = 8'h28;
  localparam logic [7:0] OFS_LEN  = 8'h2c;
  localparam logic [7:0] OFS_CMD  = 8'h30;

  localparam int STS_BUSY_BIT = 0;
  localparam int STS_DONE_BIT = 9;

  localparam int NREG = 6;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5,
    ALG_BAD    = 3'd7
  } hash_alg_e;

  function automatic logic [DW-1:0] variant_mask(input int variant);
    case (variant)
      0:       return 32'h7fff_ffff;
      1:       return 32'h3fff_ffff;
      default: return 32'h0fff_ffff;
    endcase
  endfunction

  // slot order: mode, src, dst, key, len, cmd
  function automatic logic [7:0] slot_ofs(input int idx);
    case (idx)
      0:       return OFS_MODE;
      1:       return OFS_SRC;
      2:       return OFS_DST;
      3:       return OFS_KEY;
      4:       return OFS_LEN;
      default: return OFS_CMD;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_mask(input int idx, input int variant);
    case (idx)
      1, 3:    return variant_mask(variant);
      2:       return variant_mask(variant) & ~32'h7;
      4:       return 32'h0fff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/hash_mask_reg.sv
module hash_mask_reg
  import hash_regs_pkg::*;
#(
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_d;
  end

  // R2/R3/R4: stored value is last write under the slot mask
  assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == ($past(wdata) & MASK)));
endmodule

// File: rtl/hash_status_ctl.sv
module hash_status_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic clr_wr_i,
  input  logic clr_bit_i,
  output logic busy_o,
  output logic flag_o
);
  logic busy_d, flag_d;

  always_comb begin
    busy_d = busy_o;
    if (start_i)     busy_d = 1'b1;
    else if (done_i) busy_d = 1'b0;

    flag_d = flag_o;
    if (done_i)                     flag_d = 1'b1;
    else if (clr_wr_i && clr_bit_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      busy_o <= busy_d;
      flag_o <= flag_d;
    end
  end

  assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  assert_done_clears_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> !busy_o);
  assert_done_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> flag_o);
  assert_clear_drops_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && clr_bit_i && !done_i) |=> !flag_o);
  assert_zero_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !(clr_wr_i && clr_bit_i)) |=> flag_o);
endmodule

// File: rtl/hash_cmd_decode.sv
module hash_cmd_decode
  import hash_regs_pkg::*;
(
  input  logic [3:0] alg_bits,   // command bits {10,6,5,4}
  input  logic       be_bit,
  input  logic       le_bit,
  input  logic       sg_bit,
  output hash_alg_e  algo,
  output logic       sha_be,
  output logic       md5_le,
  output logic       sg_mode
);
  always_comb begin
    case (alg_bits)
      4'b0000: algo = ALG_MD5;
      4'b0010: algo = ALG_SHA1;
      4'b0100: algo = ALG_SHA224;
      4'b0101: algo = ALG_SHA256;
      4'b1110: algo = ALG_SHA384;
      4'b0110: algo = ALG_SHA512;
      default: algo = ALG_BAD;
    endcase
    sha_be  = be_bit;
    md5_le  = le_bit;
    sg_mode = sg_bit;
  end
endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
  import hash_regs_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          hash_done,
  output logic          hash_start,
  output logic [2:0]    hash_algo,
  output logic          hash_sg_mode,
  output logic          hash_sha_be,
  output logic          hash_md5_le,
  output logic [31:0]   hash_src,
  output logic [31:0]   hash_dst,
  output logic [31:0]   hash_len,
  output logic          hash_irq
);
  localparam int SLOT_SRC = 1;
  localparam int SLOT_DST = 2;
  localparam int SLOT_LEN = 4;
  localparam int SLOT_CMD = 5;

  logic [DW-1:0] slot_q [NREG];
  logic          slot_we [NREG];
  logic          sts_we, cmd_we;
  logic          start_q, start_d;
  logic          busy, flag;
  hash_alg_e     algo_e;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign slot_we[g] = reg_we && (reg_addr == AW'(slot_ofs(g)));
    hash_mask_reg #(.MASK(slot_mask(g, VARIANT))) u_reg (
      .clk(clk), .rst_n(rst_n), .we(slot_we[g]),
      .wdata(reg_wdata), .q(slot_q[g])
    );
  end

  assign cmd_we = slot_we[SLOT_CMD];
  assign sts_we = reg_we && (reg_addr == AW'(OFS_STS));

  always_comb start_d = cmd_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  hash_status_ctl u_sts (
    .clk(clk), .rst_n(rst_n),
    .start_i(cmd_we), .done_i(hash_done),
    .clr_wr_i(sts_we), .clr_bit_i(reg_wdata[STS_DONE_BIT]),
    .busy_o(busy), .flag_o(flag)
  );

  hash_cmd_decode u_dec (
    .alg_bits({slot_q[SLOT_CMD][10], slot_q[SLOT_CMD][6],
               slot_q[SLOT_CMD][5],  slot_q[SLOT_CMD][4]}),
    .be_bit(slot_q[SLOT_CMD][3]),
    .le_bit(slot_q[SLOT_CMD][2]),
    .sg_bit(slot_q[SLOT_CMD][18]),
    .algo(algo_e), .sha_be(hash_sha_be),
    .md5_le(hash_md5_le), .sg_mode(hash_sg_mode)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (reg_addr == AW'(slot_ofs(i))) reg_rdata = slot_q[i];
    if (reg_addr == AW'(OFS_STS)) begin
      reg_rdata[STS_BUSY_BIT] = busy;
      reg_rdata[STS_DONE_BIT] = flag;
    end
  end

  assign hash_start = start_q;
  assign hash_algo  = algo_e;
  assign hash_src   = slot_q[SLOT_SRC];
  assign hash_dst   = slot_q[SLOT_DST];
  assign hash_len   = slot_q[SLOT_LEN];
  assign hash_irq   = flag;

  assert_start_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |-> $past(reg_we && (reg_addr == AW'(OFS_CMD))));
  assert_irq_rise_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hash_irq) |-> $past(hash_done));
  assert_dst_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(OFS_DST)) |=> (hash_dst[2:0] == 3'b000));
endmodule

// File: tb/tb_hash_ctl_regs.sv
module tb_hash_ctl_regs;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        hash_done = 1'b0;

  logic [31:0] rdata0, rdata1, rdata2;
  logic        start0, start1, start2;
  logic [2:0]  algo0, algo1, algo2;
  logic        sg0, sg1, sg2, be0, be1, be2, le0, le1, le2;
  logic [31:0] src0, src1, src2, dst0, dst1, dst2, len0, len1, len2;
  logic        irq0, irq1, irq2;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #(CYC/2) clk = ~clk;

  hash_ctl_regs #(.VARIANT(0)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .hash_done(hash_done),
    .hash_start(start0), .hash_algo(algo0), .hash_sg_mode(sg0),
    .hash_sha_be(be0), .hash_md5_le(le0), .hash_src(src0),
    .hash_dst(dst0), .hash_len(len0), .hash_irq(irq0));
  hash_ctl_regs #(.VARIANT(1)) dut_v1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .hash_done(hash_done),
    .hash_start(start1), .hash_algo(algo1), .hash_sg_mode(sg1),
    .hash_sha_be(be1), .hash_md5_le(le1), .hash_src(src1),
    .hash_dst(dst1), .hash_len(len1), .hash_irq(irq1));
  hash_ctl_regs #(.VARIANT(2)) dut_v2 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata2), .hash_done(hash_done),
    .hash_start(start2), .hash_algo(algo2), .hash_sg_mode(sg2),
    .hash_sha_be(be2), .hash_md5_le(le2), .hash_src(src2),
    .hash_dst(dst2), .hash_len(len2), .hash_irq(irq2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd0(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rdata0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    hash_done = 1'b1;
    @(negedge clk);
    hash_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    foreach (ofs[i]) begin
      rd0(ofs[i], v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq0}, 32'h0);
    chk("R1 start", {31'b0, start0}, 32'h0);
  endtask
  logic [7:0] ofs [7] = '{8'h10, 8'h1c, 8'h20, 8'h24, 8'h28, 8'h2c, 8'h30};

  task automatic t_masks();
    logic [31:0] v;
    wr(8'h20, 32'hffff_ffff);
    wr(8'h24, 32'hffff_ffff);
    wr(8'h28, 32'hffff_ffff);
    wr(8'h2c, 32'hffff_ffff);
    reg_addr = 8'h20; #1;
    chk("R2 src v0", rdata0, 32'h7fff_ffff);
    chk("R2 src v1", rdata1, 32'h3fff_ffff);
    chk("R2 src v2", rdata2, 32'h0fff_ffff);
    reg_addr = 8'h28; #1;
    chk("R2 key v1", rdata1, 32'h3fff_ffff);
    reg_addr = 8'h24; #1;
    chk("R3 dst v0", rdata0, 32'h7fff_fff8);
    chk("R3 dst v1", rdata1, 32'h3fff_fff8);
    chk("R3 dst v2", rdata2, 32'h0fff_fff8);
    chk("R3 dst port", dst0, 32'h7fff_fff8);
    reg_addr = 8'h2c; #1;
    chk("R4 len v0", rdata0, 32'h0fff_ffff);
    chk("R4 len v1", rdata1, 32'h0fff_ffff);
    chk("R4 len v2", rdata2, 32'h0fff_ffff);
    wr(8'h10, 32'hdead_beef);
    rd0(8'h10, v);
    chk("R1 mode readback", v, 32'hdead_beef);
    wr(8'h20, 32'h0); wr(8'h24, 32'h0); wr(8'h2c, 32'h0);
    rd0(8'h20, v); chk("R2 src zero", v, 32'h0);
    rd0(8'h24, v); chk("R3 dst zero", v, 32'h0);
  endtask

  task automatic t_cmd(input logic [31:0] cmd, input logic [2:0] exp_alg,
                       input bit ebe, input bit ele, input bit esg);
    logic [31:0] v;
    wr(8'h30, cmd);
    chk("R5 start high", {31'b0, start0}, 32'h1);
    chk("R11 algo", {29'b0, algo0}, {29'b0, exp_alg});
    chk("R11 be", {31'b0, be0}, {31'b0, ebe});
    chk("R11 le", {31'b0, le0}, {31'b0, ele});
    chk("R11 sg", {31'b0, sg0}, {31'b0, esg});
    rd0(8'h1c, v);
    chk("R6 busy set", v, 32'h1);
    @(negedge clk);
    chk("R5 start one cycle", {31'b0, start0}, 32'h0);
    rd0(8'h30, v);
    chk("R5 cmd readback", v, cmd);
    done_pulse();
    rd0(8'h1c, v);
    chk("R6 R7 status after done", v, 32'h200);
    chk("R7 irq", {31'b0, irq0}, 32'h1);
    wr(8'h1c, 32'h200);
    rd0(8'h1c, v);
    chk("R8 clear", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(8'h30, 32'h58);
    done_pulse();
    wr(8'h1c, 32'hffff_fdff);
    rd0(8'h1c, v);
    chk("R8 zero write keeps flag", v, 32'h200);
    chk("R10 crypto/rsa bits zero", v & 32'h3006, 32'h0);
    chk("R8 irq kept", {31'b0, irq0}, 32'h1);
    wr(8'h1c, 32'h200);
    chk("R8 irq cleared", {31'b0, irq0}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(8'h30, 32'h60);
    @(negedge clk);
    hash_done = 1'b1;
    reg_addr = 8'h1c; reg_wdata = 32'h200; reg_we = 1'b1;
    @(negedge clk);
    hash_done = 1'b0; reg_we = 1'b0;
    rd0(8'h1c, v);
    chk("R9 done beats clear", v, 32'h200);
    wr(8'h1c, 32'h200);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd0(8'h00, v); chk("R12 unmapped 0x00", v, 32'h0);
    rd0(8'h34, v); chk("R12 unmapped 0x34", v, 32'h0);
    wr(8'h40, 32'hffff_ffff);
    rd0(8'h40, v); chk("R12 unmapped write", v, 32'h0);
  endtask

  initial begin
    #(CYC * 50000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_cmd(32'h0000_0058, 3'd3, 1'b1, 1'b0, 1'b0); // SHA-256, BE
    t_cmd(32'h0000_0004, 3'd0, 1'b0, 1'b1, 1'b0); // MD5, LE
    t_cmd(32'h0004_0068, 3'd5, 1'b1, 1'b0, 1'b1); // SHA-512, list
    t_cmd(32'h0000_0460, 3'd4, 1'b0, 1'b0, 1'b0); // SHA-384
    t_cmd(32'h0000_0020, 3'd1, 1'b0, 1'b0, 1'b0); // SHA-1
    t_cmd(32'h0000_0040, 3'd2, 1'b0, 1'b0, 1'b0); // SHA-224
    t_cmd(32'h0000_0010, 3'd7, 1'b0, 1'b0, 1'b0); // invalid
    t_w1c();
    t_collide();
    t_unmapped();
    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule